// File: doc/BRIEF.md
# Strobed Overvoltage Fault Filter

In a flyback converter the auxiliary winding follows the output voltage only while the power switch is off. A comparator checks that winding through a divider against a fixed 3 V reference and gives one bit. This block turns that noisy bit into a fault request that a shutdown controller can trust. It takes at most one sample of the comparator in each oscillator cycle. The sample is taken at a strobe placed a fixed number of clock ticks into the switch-off interval, which skips the ringing at the start of that interval. The block counts how many cycles in a row gave a trip. It raises a fault request when the run reaches its limit, which is four by default.

The comparator level at any clock edge other than the strobe has no effect. A cycle that samples no trip resets the run to zero. A cycle that ends without any sample, because the off interval was too short, also resets the run. Once the fault request is raised it stays high until a clear pulse, a reset, or the enable going low. The enable input parks the whole filter while the protection is not in use.

Top module: `ovstrobe_filter`

## Requirements
- R1: The comparator is sampled only at the strobe. The strobe is the (STROBE_DLY+1)-th consecutive rising edge at which `sw_on` is low. The comparator level at every other edge has no effect. The result of a sample shows on `trip_run` after that same edge.
- R2: At most one sample is taken per oscillator cycle. A cycle runs from one `cyc_start` pulse to the next. Turning the switch on and off again inside the same cycle does not give a second sample. No sample is taken at an edge where `cyc_start` is high.
- R3: A sample that finds `ov_cmp` high adds exactly one to `trip_run`. The count saturates at LIMIT (default 4) and never goes above it.
- R4: A sample that finds `ov_cmp` low sets `trip_run` to 0.
- R5: At a `cyc_start` edge, if the cycle that just ended took no sample, `trip_run` is set to 0. Until that edge the count keeps its value.
- R6: `fault_req` rises at the same edge at which `trip_run` goes from LIMIT-1 to LIMIT. This happens after LIMIT consecutive tripped cycles.
- R7: Once high, `fault_req` stays high whatever later samples show, until a clear, a disable or a reset.
- R8: `flt_clr` high at an edge drives `trip_run` to 0 and `fault_req` low after that edge. It wins over a trip sampled at the same edge.
- R9: While `en` is low, `trip_run` is held at 0 and `fault_req` is held low, and no sample is taken. After `en` returns high, a new run has to reach LIMIT from zero.
- R10: `rst` is synchronous and active high. It sets `trip_run` to 0 and `fault_req` low, and the run restarts from zero after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Filter enable; low parks the filter |
| sw_on | input | 1 | High while the power switch conducts |
| cyc_start | input | 1 | One-tick pulse at the start of each oscillator cycle |
| ov_cmp | input | 1 | Comparator result, high when the sense pin is above 3 V |
| flt_clr | input | 1 | Clears the fault request and the run |
| fault_req | output | 1 | Latched overvoltage fault request |
| trip_run | output | CW | Consecutive tripped cycles, saturating at LIMIT |

## Verification
The bench uses the defaults STROBE_DLY = 3 and LIMIT = 4. With these values an off interval of three ticks is one tick too short for a sample, and an interval of four ticks is just long enough, so both sides of the strobe point can be reached directly. A fourth trip is needed before the fault appears and a fifth shows saturation, all within short runs. The comparator is driven high everywhere except at the strobe, and the reverse, so that it is clear which edge decides the result. The cases where a clear or a disable meets a run about to complete are driven on purpose.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_ZERO = 2'd2
  } cnt_act_e;

  // Bits needed to hold values 0..v, at least one.
  function automatic int unsigned ovf_width(input int unsigned v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ovf_strobe_gen.sv
module ovf_strobe_gen import ovf_pkg::*; #(
  parameter int unsigned STROBE_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sw_on,
  input  logic cyc_start,
  output logic strobe,
  output logic miss
);

  logic at_point;
  logic smp_done_q;

  generate
    if (STROBE_DLY == 0) begin : g_no_delay
      assign at_point = !sw_on;
    end else begin : g_delay
      localparam int unsigned DW = ovf_width(STROBE_DLY);
      localparam logic [DW-1:0] DLY_TOP = DW'(STROBE_DLY);
      logic [DW-1:0] off_ticks_q;

      always_ff @(posedge clk) begin
        if (rst || !en) begin
          off_ticks_q <= '0;
        end else if (sw_on) begin
          off_ticks_q <= '0;
        end else if (off_ticks_q != DLY_TOP) begin
          off_ticks_q <= off_ticks_q + 1'b1;
        end
      end

      assign at_point = !sw_on && (off_ticks_q == DLY_TOP);
    end
  endgenerate

  always_comb begin
    strobe = !rst && en && at_point && !smp_done_q && !cyc_start;
    miss   = !rst && en && cyc_start && !smp_done_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      smp_done_q <= 1'b0;
    end else if (cyc_start) begin
      smp_done_q <= 1'b0;
    end else if (strobe) begin
      smp_done_q <= 1'b1;
    end
  end

  AST_STROBE_IN_OFF: assert property (@(posedge clk) disable iff (rst)
    strobe |-> !sw_on); // R1
  AST_STROBE_AFTER_DELAY: assert property (@(posedge clk) disable iff (rst)
    strobe |-> ((STROBE_DLY == 0) || !$past(sw_on))); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe) && !cyc_start) |-> !strobe); // R2

endmodule

// File: rtl/ovf_run_count.sv
module ovf_run_count import ovf_pkg::*; #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned CW = ovf_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic          strobe,
  input  logic          miss,
  input  logic          ov_trip,
  output logic [CW-1:0] cnt_q,
  output logic          hit
);

  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
  localparam logic [CW-1:0] PRE_V = CW'(LIMIT - 1);

  cnt_act_e act;

  always_comb begin
    if (!en || clr) begin
      act = CNT_ZERO;
    end else if (miss) begin
      act = CNT_ZERO;
    end else if (strobe) begin
      act = ov_trip ? CNT_INC : CNT_ZERO;
    end else begin
      act = CNT_HOLD;
    end
    hit = en && !clr && strobe && ov_trip && (cnt_q == PRE_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (act)
        CNT_ZERO: cnt_q <= '0;
        CNT_INC:  if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_V); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1))); // R3
  AST_NOSAMPLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(miss) |-> (cnt_q == '0)); // R5

endmodule

// File: rtl/ovf_fault_hold.sv
module ovf_fault_hold (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  logic hit,
  output logic fault_q
);

  always_ff @(posedge clk) begin
    if (rst || !en || clr) begin
      fault_q <= 1'b0;
    end else if (hit) begin
      fault_q <= 1'b1;
    end
  end

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(fault_q) && $past(en) && !$past(clr)) |-> fault_q); // R7
  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) || !$past(en)) |-> !fault_q); // R8

endmodule

// File: rtl/ovstrobe_filter.sv
module ovstrobe_filter import ovf_pkg::*; #(
  parameter int unsigned STROBE_DLY = 3,
  parameter int unsigned LIMIT      = 4,
  localparam int unsigned CW = ovf_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sw_on,
  input  logic          cyc_start,
  input  logic          ov_cmp,
  input  logic          flt_clr,
  output logic          fault_req,
  output logic [CW-1:0] trip_run
);

  logic strobe;
  logic miss;
  logic hit;

  ovf_strobe_gen #(.STROBE_DLY(STROBE_DLY)) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .sw_on     (sw_on),
    .cyc_start (cyc_start),
    .strobe    (strobe),
    .miss      (miss)
  );

  ovf_run_count #(.LIMIT(LIMIT)) u_count (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .clr     (flt_clr),
    .strobe  (strobe),
    .miss    (miss),
    .ov_trip (ov_cmp),
    .cnt_q   (trip_run),
    .hit     (hit)
  );

  ovf_fault_hold u_fault (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .clr     (flt_clr),
    .hit     (hit),
    .fault_q (fault_req)
  );

  AST_FAULT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_req) |-> (trip_run == CW'(LIMIT))); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((trip_run == '0) && !fault_req)); // R9

endmodule

// File: tb/ovstrobe_filter_bench.sv
module ovstrobe_filter_bench;

  localparam int D = 3;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst, en, sw_on, cyc_start, ov_cmp, flt_clr;
  logic fault_req;
  logic [2:0] trip_run;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  int exp_flt = 0;
  bit smp_seen = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ovstrobe_filter #(.STROBE_DLY(D), .LIMIT(L)) u_ovstrobe_filter (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .sw_on     (sw_on),
    .cyc_start (cyc_start),
    .ov_cmp    (ov_cmp),
    .flt_clr   (flt_clr),
    .fault_req (fault_req),
    .trip_run  (trip_run)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // One oscillator cycle: on_t ticks on, off_t ticks off. ov_s is the
  // comparator at the strobe tick, ov_o everywhere else.
  task automatic run_cycle(input int on_t, input int off_t, input bit ov_s,
                           input bit ov_o, input bit clr_s, input string tag);
    cyc_start = 1'b1; sw_on = 1'b1; ov_cmp = ov_o; flt_clr = 1'b0;
    step();
    cyc_start = 1'b0;
    if (!smp_seen || !en) exp_cnt = 0;   // R5 / R9
    if (!en) exp_flt = 0;
    smp_seen = 1'b0;
    chk({tag, " boundary count"}, trip_run, exp_cnt);
    for (int i = 1; i < on_t; i++) step();
    sw_on = 1'b0;
    for (int k = 0; k < off_t; k++) begin
      ov_cmp  = (k == D) ? ov_s : ov_o;
      flt_clr = (k == D) ? clr_s : 1'b0;
      step();
      if (k == D && en) begin
        smp_seen = 1'b1;
        if (clr_s) begin
          exp_cnt = 0; exp_flt = 0;
        end else if (ov_s) begin
          if (exp_cnt == L - 1) exp_flt = 1;
          if (exp_cnt < L) exp_cnt++;
        end else begin
          exp_cnt = 0;
        end
      end
    end
    flt_clr = 1'b0; ov_cmp = 1'b0;
    chk({tag, " count"}, trip_run, exp_cnt);
    chk({tag, " fault"}, fault_req, exp_flt);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; sw_on = 1'b0; cyc_start = 1'b0;
    ov_cmp = 1'b1; flt_clr = 1'b0;
    repeat (6) step();
    chk("R10 reset count", trip_run, 0);
    chk("R10 reset fault", fault_req, 0);
    rst = 1'b0;
    step();
    chk("R10 after release count", trip_run, 0);
    ov_cmp = 1'b0;
  endtask

  task automatic t_count_and_zero();
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R3 first trip");
    chk("R3 one trip gives one", trip_run, 1);
    run_cycle(3, 6, 1'b1, 1'b1, 1'b0, "R3 long high level");
    chk("R3 level held high counts once", trip_run, 2);
    run_cycle(3, 6, 1'b0, 1'b0, 1'b0, "R4 clean sample");
    chk("R4 clean sample zeroes run", trip_run, 0);
  endtask

  task automatic t_strobe_only();
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R1 setup");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R1 setup");
    run_cycle(4, 8, 1'b0, 1'b1, 1'b0, "R1 high off strobe");
    chk("R1 level away from strobe ignored", trip_run, 0);
    run_cycle(2, 4, 1'b1, 1'b0, 1'b0, "R1 tight off interval");
    chk("R1 shortest sampling interval", trip_run, 1);
  endtask

  task automatic t_one_per_cycle();
    // run is 1 here
    cyc_start = 1'b1; sw_on = 1'b1; ov_cmp = 1'b1;
    step();
    cyc_start = 1'b0;
    sw_on = 1'b0;
    repeat (D + 2) step();
    chk("R2 first off stretch counts", trip_run, 2);
    sw_on = 1'b1;
    repeat (2) step();
    sw_on = 1'b0;
    repeat (D + 3) step();
    chk("R2 second off stretch ignored", trip_run, 2);
    ov_cmp = 1'b0;
    exp_cnt = 2; smp_seen = 1'b1;
    run_cycle(3, 6, 1'b0, 1'b0, 1'b0, "R4 zero after R2");
  endtask

  task automatic t_limit_fault();
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R6 trip 1");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R6 trip 2");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R6 trip 3");
    chk("R6 no fault at three", fault_req, 0);
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R6 trip 4");
    chk("R6 fault at four", fault_req, 1);
    chk("R6 run at limit", trip_run, L);
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R3 trip 5");
    chk("R3 saturates at limit", trip_run, L);
  endtask

  task automatic t_sticky();
    run_cycle(3, 6, 1'b0, 1'b0, 1'b0, "R7 clean after fault");
    run_cycle(3, 2, 1'b0, 1'b0, 1'b0, "R7 no sample after fault");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R7 trip after fault");
    chk("R7 fault held", fault_req, 1);
  endtask

  task automatic t_clear();
    run_cycle(3, 6, 1'b1, 1'b0, 1'b1, "R8 clear with fault set");
    chk("R8 fault dropped", fault_req, 0);
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R8 trip 1");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R8 trip 2");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R8 trip 3");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b1, "R8 clear beats fourth trip");
    chk("R8 no fault after coincident clear", fault_req, 0);
    chk("R8 run zero after coincident clear", trip_run, 0);
  endtask

  task automatic t_missed_sample();
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R5 trip 1");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R5 trip 2");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R5 trip 3");
    run_cycle(3, D, 1'b1, 1'b1, 1'b0, "R5 off one tick short");
    chk("R5 run kept until boundary", trip_run, 3);
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R5 after missed cycle");
    chk("R5 run restarted", trip_run, 1);
    chk("R5 no fault", fault_req, 0);
  endtask

  task automatic t_enable();
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R9 pre trip");
    en = 1'b0;
    for (int c = 0; c < 5; c++) run_cycle(3, 6, 1'b1, 1'b1, 1'b0, "R9 disabled");
    chk("R9 disabled run", trip_run, 0);
    chk("R9 disabled fault", fault_req, 0);
    en = 1'b1;
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R9 re-enabled 1");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R9 re-enabled 2");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R9 re-enabled 3");
    chk("R9 run starts from zero", fault_req, 0);
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R9 re-enabled 4");
    chk("R9 fault after full run", fault_req, 1);
    en = 1'b0;
    step();
    chk("R9 disable drops fault", fault_req, 0);
    en = 1'b1;
    exp_cnt = 0; exp_flt = 0; smp_seen = 1'b0;
  endtask

  task automatic t_reset_mid();
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R10 pre 1");
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R10 pre 2");
    rst = 1'b1;
    step();
    chk("R10 mid reset run", trip_run, 0);
    rst = 1'b0;
    exp_cnt = 0; smp_seen = 1'b0;
    run_cycle(3, 6, 1'b1, 1'b0, 1'b0, "R10 after reset");
    chk("R10 run restarts at one", trip_run, 1);
  endtask

  initial begin
    t_reset();
    t_count_and_zero();
    t_strobe_only();
    t_one_per_cycle();
    t_limit_fault();
    t_sticky();
    t_clear();
    t_missed_sample();
    t_enable();
    t_reset_mid();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule